// File: doc/BRIEF.md
# Triggered Right Shift Register

This block holds a value of one or two 16-bit words and moves it toward the least significant end by a chosen number of bit positions, once for each low-to-high transition of a trigger input. The whole count is applied in a single clock cycle. Every position vacated at the top takes a fill bit chosen by the caller, and the bit that leaves the bottom last is kept in a carry flag.

A mode input selects a 16-bit shift that uses only the low word, or a 32-bit shift over the pair {high word, low word}. A synchronous load port sets both words to a starting value, for example from a start-up pulse, before any shift. The trigger is sampled on the clock and compared with its value from the previous cycle. A load in the same cycle as a trigger edge wins.

Top module: `word_shift_unit`

## Requirements
- R1: While the reset is asserted, and until the first load or shift after it, the low word, the high word and the carry all read 0.
- R2: With `load_en` high at a clock edge, `lo_q` and `hi_q` take `load_lo` and `load_hi` at that edge in either mode, and `carry_q` keeps its value.
- R3: A shift occurs only at a clock edge where `trig` is 1 and was 0 at the previous clock edge. Holding `trig` high gives no further shift.
- R4: A shift by n moves the active value n places toward bit 0. The top n bits of the active width take `fill_bit`.
- R5: After a shift by n, `carry_q` equals bit n-1 of the active value from before the shift, which is the last bit shifted out.
- R6: With `dbl_mode` = 0 (word mode), the active width is 16 bits in `lo_q`, and `hi_q` is not changed by a shift.
- R7: With `dbl_mode` = 1 (double mode), the active value is {`hi_q`,`lo_q`}, 32 bits, so bit 0 of the high word moves into bit 15 of the low word.
- R8: A shift count of 0, or one larger than the active width, leaves both words and the carry unchanged on a trigger edge.
- R9: When `load_en` and a trigger edge fall in the same cycle, the load is applied and no shift occurs.
- R10: A count equal to the active width fills the whole active value with `fill_bit` and sets the carry to the former top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Synchronous load of both words |
| load_lo | input | 16 | Value loaded into the low word |
| load_hi | input | 16 | Value loaded into the high word |
| dbl_mode | input | 1 | 0: 16-bit shift of the low word; 1: 32-bit shift of {high, low} |
| fill_bit | input | 1 | Bit entering the vacated top positions |
| shift_cnt | input | 6 | Number of positions to shift per trigger edge |
| trig | input | 1 | Trigger; a shift on each sampled rising transition |
| lo_q | output | 16 | Low word |
| hi_q | output | 16 | High word |
| carry_q | output | 1 | Last bit shifted out |

## Verification
The bench uses the default word width of 16, so the counter is 6 bits wide. Counts 0 to 39 therefore cover the zero count, every legal count in both modes, the full-width counts 16 and 32, and counts beyond the active width. The known cases (29 shifted by 2 twice, and a 32-bit shift by 1 with fill 1 across the word boundary) run first. A fixed-seed random stream then mixes loads, trigger pulses, held triggers and mode changes, and every cycle is compared with a reference model in the bench.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic {
    WS_WORD   = 1'b0,
    WS_DOUBLE = 1'b1
  } ws_mode_e;
endpackage

// File: rtl/ws_rst_sync.sv
module ws_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ws_edge_det.sv
module ws_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  assign prev_d = trig;
  assign rise   = trig & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R3: two rising edges cannot be seen in consecutive cycles
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ws_shift_core.sv
module ws_shift_core
  import ws_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int DW    = 2 * WORD_W,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  logic [DW-1:0]    val,
  input  ws_mode_e         mode,
  input  logic             fill,
  input  logic [CNT_W-1:0] cnt,
  output logic [DW-1:0]    res,
  output logic             cout,
  output logic             cnt_ok
);
  int act_w;
  int c;

  always_comb begin
    act_w  = (mode == WS_DOUBLE) ? DW : WORD_W;
    c      = int'(cnt);
    cnt_ok = (c != 0) && (c <= act_w);
  end

  // Result bit i takes source bit i+c when it lies inside the active width,
  // otherwise the fill bit; bits outside the active width pass through.
  always_comb begin
    res = val;
    for (int i = 0; i < DW; i++) begin
      if (i < act_w) begin
        res[i] = fill;
        for (int j = 0; j < DW; j++) begin
          if ((j == i + c) && (j < act_w)) res[i] = val[j];
        end
      end
    end
  end

  always_comb begin
    cout = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i + 1 == c) cout = val[i];
    end
  end
endmodule

// File: rtl/ws_state_reg.sv
module ws_state_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_lo,
  input  logic [WORD_W-1:0] load_hi,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] sh_lo,
  input  logic [WORD_W-1:0] sh_hi,
  input  logic              sh_cy,
  output logic [WORD_W-1:0] lo_q,
  output logic [WORD_W-1:0] hi_q,
  output logic              cy_q
);
  logic [WORD_W-1:0] lo_d, hi_d;
  logic              cy_d;
  logic              upd_en;

  // R9: the load branch is taken first
  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    cy_d   = cy_q;
    upd_en = 1'b0;
    if (load_en) begin
      lo_d   = load_lo;
      hi_d   = load_hi;
      upd_en = 1'b1;
    end else if (shift_en) begin
      lo_d   = sh_lo;
      hi_d   = sh_hi;
      cy_d   = sh_cy;
      upd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      cy_q <= 1'b0;
    end else if (upd_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      cy_q <= cy_d;
    end
  end
endmodule

// File: rtl/word_shift_unit.sv
module word_shift_unit
  import ws_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int DW    = 2 * WORD_W,
  localparam int CNT_W = $clog2(DW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_lo,
  input  logic [WORD_W-1:0] load_hi,
  input  logic              dbl_mode,
  input  logic              fill_bit,
  input  logic [CNT_W-1:0]  shift_cnt,
  input  logic              trig,
  output logic [WORD_W-1:0] lo_q,
  output logic [WORD_W-1:0] hi_q,
  output logic              carry_q
);
  logic          rst_sync_n;
  logic          rise;
  logic          cnt_ok;
  logic          shift_en;
  logic [DW-1:0] sh_res;
  logic          sh_cy;
  ws_mode_e      mode;

  assign mode = ws_mode_e'(dbl_mode);

  ws_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ws_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .trig  (trig),
    .rise  (rise)
  );

  ws_shift_core #(.WORD_W(WORD_W)) u_core (
    .val    ({hi_q, lo_q}),
    .mode   (mode),
    .fill   (fill_bit),
    .cnt    (shift_cnt),
    .res    (sh_res),
    .cout   (sh_cy),
    .cnt_ok (cnt_ok)
  );

  assign shift_en = rise & cnt_ok;

  ws_state_reg #(.WORD_W(WORD_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (load_en),
    .load_lo  (load_lo),
    .load_hi  (load_hi),
    .shift_en (shift_en),
    .sh_lo    (sh_res[WORD_W-1:0]),
    .sh_hi    (sh_res[DW-1:WORD_W]),
    .sh_cy    (sh_cy),
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .cy_q     (carry_q)
  );

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_en |=> (lo_q == $past(load_lo)) && (hi_q == $past(load_hi)) && $stable(carry_q));

  a_r3_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_en && !rise) |=> $stable(lo_q) && $stable(hi_q) && $stable(carry_q));

  a_r6_word_hi_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_en && !dbl_mode) |=> $stable(hi_q));

  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_en && shift_cnt == '0) |=> $stable(lo_q) && $stable(hi_q) && $stable(carry_q));

  a_r10_word_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_en && rise && !dbl_mode && int'(shift_cnt) == WORD_W)
      |=> (lo_q == {WORD_W{$past(fill_bit)}}) && (carry_q == $past(lo_q[WORD_W-1])));
endmodule

// File: tb/word_shift_unit_tb_top.sv
module word_shift_unit_tb_top;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en;
  logic [15:0] load_lo, load_hi;
  logic        dbl_mode, fill_bit, trig;
  logic [5:0]  shift_cnt;
  logic [15:0] lo_q, hi_q;
  logic        carry_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [15:0] m_lo, m_hi;
  logic        m_cy, m_prev;

  always #5 clk = ~clk;

  word_shift_unit #(.WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_lo(load_lo),
    .load_hi(load_hi), .dbl_mode(dbl_mode), .fill_bit(fill_bit),
    .shift_cnt(shift_cnt), .trig(trig), .lo_q(lo_q), .hi_q(hi_q),
    .carry_q(carry_q)
  );

  // Reference: returns {carry, result} for a right shift of v over width w by n
  function automatic logic [32:0] ref_shift(logic [31:0] v, int w, int n, logic f);
    logic [31:0] full, r;
    full = (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    r    = (v & full) >> n;
    if (f) r = r | (full & ~(full >> n));
    return {v[n-1], r};
  endfunction

  task automatic check(string tag, logic [15:0] elo, logic [15:0] ehi, logic ecy);
    n_checks++;
    if (lo_q !== elo || hi_q !== ehi || carry_q !== ecy) begin
      n_fail++;
      $display("FAIL %s: got lo=%h hi=%h cy=%b, expected lo=%h hi=%h cy=%b",
               tag, lo_q, hi_q, carry_q, elo, ehi, ecy);
    end
  endtask

  // Drives one cycle (called at a falling edge), updates the model, checks.
  task automatic step(logic ld, logic [15:0] llo, logic [15:0] lhi,
                      logic dbl, logic f, logic [5:0] cnt, logic tg);
    string tag;
    logic [32:0] r;
    int w;
    logic rise;
    load_en = ld; load_lo = llo; load_hi = lhi;
    dbl_mode = dbl; fill_bit = f; shift_cnt = cnt; trig = tg;
    @(posedge clk);
    w    = dbl ? 32 : 16;
    rise = tg && !m_prev;
    m_prev = tg;
    if (ld) begin
      tag  = rise ? "R9 load beats edge" : "R2 load";
      m_lo = llo; m_hi = lhi;
    end else if (!rise) begin
      tag = "R3 no edge";
    end else if (cnt == 0 || int'(cnt) > w) begin
      tag = "R8 count out of range";
    end else begin
      if (int'(cnt) == w) tag = "R10 full count";
      else if (dbl)       tag = "R7 R4 R5 double shift";
      else                tag = "R6 R4 R5 word shift";
      r = ref_shift({m_hi, m_lo}, w, int'(cnt), f);
      m_cy = r[32];
      m_lo = r[15:0];
      if (dbl) m_hi = r[31:16];
    end
    @(negedge clk);
    check(tag, m_lo, m_hi, m_cy);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; load_en = 0; load_lo = 0; load_hi = 0;
    dbl_mode = 0; fill_bit = 0; shift_cnt = 0; trig = 0;
    m_lo = 0; m_hi = 0; m_cy = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", 16'h0, 16'h0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 16'h0, 16'h0, 1'b0);

    // Word mode: 29 >> 2 -> 7 carry 0, then 1 carry 1
    step(1, 16'd29, 16'h1234, 0, 0, 6'd2, 0);
    step(0, 0, 0, 0, 0, 6'd2, 1);
    check("R4 R5 29>>2", 16'd7, 16'h1234, 1'b0);
    step(0, 0, 0, 0, 0, 6'd2, 1);
    check("R3 held trigger", 16'd7, 16'h1234, 1'b0);
    step(0, 0, 0, 0, 0, 6'd2, 0);
    step(0, 0, 0, 0, 0, 6'd2, 1);
    check("R5 R6 7>>2", 16'd1, 16'h1234, 1'b1);

    // Double mode: {0000,FFFF} >> 1 fill 1
    step(1, 16'hFFFF, 16'h0000, 1, 1, 6'd1, 0);
    step(0, 0, 0, 1, 1, 6'd1, 1);
    check("R7 double boundary", 16'h7FFF, 16'h8000, 1'b1);

    // Zero and oversize counts
    step(0, 0, 0, 1, 1, 6'd0, 0);
    step(0, 0, 0, 1, 1, 6'd0, 1);
    check("R8 zero count", 16'h7FFF, 16'h8000, 1'b1);
    step(0, 0, 0, 0, 0, 6'd20, 0);
    step(0, 0, 0, 0, 0, 6'd20, 1);
    check("R8 count above word width", 16'h7FFF, 16'h8000, 1'b1);

    // Full word count
    step(0, 0, 0, 0, 1, 6'd16, 0);
    step(0, 0, 0, 0, 0, 6'd16, 1);
    check("R10 word full", 16'h0000, 16'h8000, 1'b0);

    // Full double count
    step(1, 16'h0001, 16'h8001, 1, 1, 6'd32, 0);
    step(0, 0, 0, 1, 1, 6'd32, 1);
    check("R10 double full", 16'hFFFF, 16'hFFFF, 1'b1);

    // Load together with edge
    step(0, 0, 0, 0, 0, 6'd3, 0);
    step(1, 16'hA5A5, 16'h5A5A, 0, 0, 6'd3, 1);
    check("R9 load priority", 16'hA5A5, 16'h5A5A, 1'b1);

    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 8) == 0, 16'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), 6'($urandom % 40), 1'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule